// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a register-mapped bank of general-purpose pins, up to 64 of them, with each per-pin field spread over two 32-bit words. Each pin has an output-enable bit and an output-value bit. Its input level is sampled through a two-stage synchronizer and can be read back. A second register space holds four per-pin interrupt fields: an enable, an edge-polarity select, a sticky status bit that software clears by writing ones, and a wakeup mask. The bank drives one combined interrupt line and one wakeup line.

The register port is a single-cycle interface. A write takes effect on the clock edge where the write strobe is high. Read data is combinational from the address. A space-select bit picks between the pin space and the interrupt space. The hardware detects only one edge direction per pin. To sense both edges, software flips the polarity bit after each event, so a polarity write never creates an event by itself.

Top module: `gpio_edge_bank`

## Requirements
- R1: After synchronous reset every output-enable, output-value, interrupt-enable, polarity, status and wakeup bit is 0. As a result `pin_oe`, `pin_out`, `irq` and `wake` are all 0.
- R2: In the pin space (`reg_space`=0), byte offset 0x00 holds output enable and 0x18 holds output value, for pins 0..31. Pins 32 and above use the word at offset +4. `pin_oe` and `pin_out` show the stored bits from the cycle after the write.
- R3: Pin-space offset 0x10 (+4 for the upper pins) reads the synchronized pin level. The level is visible two clock edges after the pin changes, not after one. Writes to this offset have no effect.
- R4: In the interrupt space (`reg_space`=1), offset 0x00 is enable, 0x08 is polarity, 0x10 is status and 0x18 is wakeup mask, each with a second word at +4.
- R5: With polarity 0, a low-to-high pin transition sets that pin's status bit. With polarity 1, a high-to-low transition sets it. A transition in the other direction sets nothing.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a qualifying edge occurs in the same cycle as a clear of that status bit, the bit stays set.
- R8: Changing a polarity bit never sets a status bit. Only pin transitions do.
- R9: `irq` is high exactly when some pin has both status and enable set. Status still latches on pins whose enable is 0.
- R10: `wake` is high exactly when some pin has both status and wakeup mask set, whatever the enable bits hold.
- R11: The following all read as zero and take no writes: bits for pins at or above NPINS (tested with NPINS of 36 and 30), pin-space offset 0x08, and any address whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_space | input | 1 | 0 = pin space, 1 = interrupt space |
| reg_addr | input | 5 | Byte address within the space |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_oe | output | NPINS | Per-pin drive enable |
| pin_out | output | NPINS | Per-pin drive value |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wakeup request |

## Verification
The bench sweeps a rising edge across every pin in turn, then falling edges on pins near the word boundary. A design that mapped the upper word wrongly, or that sensed the wrong direction, would set the wrong status bit or none at all. It lines up a write-one-to-clear with the exact cycle in which a new edge is detected. A design that gave the clear priority would lose that event. It also flips polarity while a pin is held high, where a design that detected level against polarity rather than sample-to-sample change would raise a false event. Finally, it checks the synchronizer depth by reading the input one edge too early, and checks unused pin bits on a 30-pin copy.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int WORD_W   = 32;
    localparam int MAX_PINS = 64;

    // pin-space field selected by address bits [4:3]
    typedef enum logic [1:0] {
        PF_DRIVE_EN = 2'd0,
        PF_HOLE     = 2'd1,
        PF_LEVEL    = 2'd2,
        PF_DRIVE_VAL = 2'd3
    } pin_field_e;

    // interrupt-space field selected by address bits [4:3]
    typedef enum logic [1:0] {
        IF_ENABLE = 2'd0,
        IF_POLAR  = 2'd1,
        IF_STATUS = 2'd2,
        IF_WAKEUP = 2'd3
    } irq_field_e;

    typedef struct packed {
        logic       we;
        logic       space;
        logic [1:0] field;
        logic       upper;
        logic       aligned;
    } reg_dec_t;

    function automatic reg_dec_t decode(input logic we, input logic space,
                                        input logic [4:0] addr);
        reg_dec_t d;
        d.we      = we;
        d.space   = space;
        d.field   = addr[4:3];
        d.upper   = addr[2];
        d.aligned = (addr[1:0] == 2'b00);
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] evt_o
);
    logic [N-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    // a transition is seen only when two successive samples differ
    for (genvar i = 0; i < N; i++) begin : g_det
        assign evt_o[i] = pol_i[i] ? (prev_q[i] & ~stage2_q[i])
                                   : (stage2_q[i] & ~prev_q[i]);
    end

    assign level_o = stage2_q;

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs #(
    parameter int N = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_en,
    input  logic         we_val,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] dat,
    output logic [N-1:0] oe_o,
    output logic [N-1:0] val_o
);
    logic [N-1:0] oe_q, val_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q  <= '0;
            val_q <= '0;
        end else begin
            if (we_en)  oe_q  <= (oe_q  & ~sel) | (dat & sel);
            if (we_val) val_q <= (val_q & ~sel) | (dat & sel);
        end
    end

    assign oe_o  = oe_q;
    assign val_o = val_q;

    // R2: an unselected lane keeps its drive enable across a write
    assert_oe_lane_hold_R2: assert property (@(posedge clk) disable iff (rst)
        we_en |=> ((oe_q & ~$past(sel)) == ($past(oe_q) & ~$past(sel))));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 36
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   we_f,
    input  logic [N-1:0] sel,
    input  logic [N-1:0] dat,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] en_o,
    output logic [N-1:0] pol_o,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] wk_o,
    output logic         irq_o,
    output logic         wake_o
);
    logic [N-1:0] en_q, pol_q, stat_q, wk_q, clr;

    assign clr = we_f[IF_STATUS] ? (sel & dat) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            stat_q <= '0;
            wk_q   <= '0;
        end else begin
            if (we_f[IF_ENABLE]) en_q  <= (en_q  & ~sel) | (dat & sel);
            if (we_f[IF_POLAR])  pol_q <= (pol_q & ~sel) | (dat & sel);
            if (we_f[IF_WAKEUP]) wk_q  <= (wk_q  & ~sel) | (dat & sel);
            // a fresh event outranks a clear in the same cycle
            stat_q <= (stat_q & ~clr) | evt_i;
        end
    end

    assign en_o   = en_q;
    assign pol_o  = pol_q;
    assign stat_o = stat_q;
    assign wk_o   = wk_q;
    assign irq_o  = |(stat_q & en_q);
    assign wake_o = |(stat_q & wk_q);

    // R8: status bits only rise where the detector reported an event
    assert_no_spurious_set_R8: assert property (@(posedge clk) disable iff (rst)
        (evt_i == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

    // R6: a one written to status clears it unless an event coincides
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~evt_i) != '0) |=> ((stat_q & $past(clr & ~evt_i)) == '0));

    // R7: coincident event and clear leaves the bit set
    assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        ((clr & evt_i) != '0) |=> ((stat_q & $past(clr & evt_i)) == $past(clr & evt_i)));

    // R9: no enabled pin means no interrupt
    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o);

    // R10: no wake-masked pin means no wakeup
    assert_wake_needs_mask_R10: assert property (@(posedge clk) disable iff (rst)
        (wk_q == '0) |-> !wake_o);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_space,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_out,
    output logic             irq,
    output logic             wake
);
    localparam int NWORDS = (NPINS + WORD_W - 1) / WORD_W;

    initial begin
        if (NPINS < 1 || NPINS > MAX_PINS || NWORDS > 2)
            $error("NPINS out of range");
    end

    reg_dec_t dec;
    assign dec = decode(reg_we, reg_space, reg_addr);

    // spread the addressed word across the pin lanes
    logic [NPINS-1:0] lane_sel, lane_dat;
    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        assign lane_sel[i] = (dec.upper == 1'(i / WORD_W));
        assign lane_dat[i] = reg_wdata[i % WORD_W];
    end

    logic wr_ok;
    assign wr_ok = dec.we & dec.aligned;

    logic pin_we_en, pin_we_val;
    assign pin_we_en  = wr_ok & ~dec.space & (pin_field_e'(dec.field) == PF_DRIVE_EN);
    assign pin_we_val = wr_ok & ~dec.space & (pin_field_e'(dec.field) == PF_DRIVE_VAL);

    logic [3:0] irq_we;
    assign irq_we = (wr_ok & dec.space) ? (4'b0001 << dec.field) : 4'b0000;

    logic [NPINS-1:0] level, evt, en_v, pol_v, stat_v, wk_v;

    gpio_out_regs #(.N(NPINS)) u_out (
        .clk    (clk),
        .rst    (rst),
        .we_en  (pin_we_en),
        .we_val (pin_we_val),
        .sel    (lane_sel),
        .dat    (lane_dat),
        .oe_o   (pin_oe),
        .val_o  (pin_out)
    );

    gpio_in_sync #(.N(NPINS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pin_in),
        .pol_i   (pol_v),
        .level_o (level),
        .evt_o   (evt)
    );

    gpio_irq_regs #(.N(NPINS)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .we_f   (irq_we),
        .sel    (lane_sel),
        .dat    (lane_dat),
        .evt_i  (evt),
        .en_o   (en_v),
        .pol_o  (pol_v),
        .stat_o (stat_v),
        .wk_o   (wk_v),
        .irq_o  (irq),
        .wake_o (wake)
    );

    function automatic logic [31:0] pick(input logic [NPINS-1:0] v, input logic upper);
        logic [2*WORD_W-1:0] pad;
        pad = '0;
        pad[NPINS-1:0] = v;
        return upper ? pad[2*WORD_W-1:WORD_W] : pad[WORD_W-1:0];
    endfunction

    always_comb begin
        reg_rdata = '0;
        if (dec.aligned) begin
            if (dec.space) begin
                unique case (irq_field_e'(dec.field))
                    IF_ENABLE: reg_rdata = pick(en_v,   dec.upper);
                    IF_POLAR:  reg_rdata = pick(pol_v,  dec.upper);
                    IF_STATUS: reg_rdata = pick(stat_v, dec.upper);
                    IF_WAKEUP: reg_rdata = pick(wk_v,   dec.upper);
                    default:   reg_rdata = '0;
                endcase
            end else begin
                unique case (pin_field_e'(dec.field))
                    PF_DRIVE_EN:  reg_rdata = pick(pin_oe,  dec.upper);
                    PF_LEVEL:     reg_rdata = pick(level,   dec.upper);
                    PF_DRIVE_VAL: reg_rdata = pick(pin_out, dec.upper);
                    default:      reg_rdata = '0;
                endcase
            end
        end
    end

    // R1: the cycle after reset every control and output is clear
    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq && !wake && stat_v == '0));

endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic        space = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [35:0] pins0 = '0;
    logic [29:0] pins1 = '0;
    logic [35:0] oe0, out0;
    logic [29:0] oe1, out1;
    logic        irq0, wake0, irq1, wake1;

    int vectors = 0;
    int miscompares = 0;

    always #4 clk = ~clk;

    gpio_edge_bank #(.NPINS(36)) u0 (
        .clk(clk), .rst(rst), .reg_we(we), .reg_space(space), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata0), .pin_in(pins0), .pin_oe(oe0),
        .pin_out(out0), .irq(irq0), .wake(wake0)
    );

    gpio_edge_bank #(.NPINS(30)) u1 (
        .clk(clk), .rst(rst), .reg_we(we), .reg_space(space), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata1), .pin_in(pins1), .pin_oe(oe1),
        .pin_out(out1), .irq(irq1), .wake(wake1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sp, input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        space = sp; addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic sp, input logic [4:0] a, output logic [31:0] v0,
                      output logic [31:0] v1);
        space = sp; addr = a;
        #1;
        v0 = rdata0; v1 = rdata1;
    endtask

    task automatic rd64(input logic sp, input logic [4:0] base, output logic [63:0] v);
        logic [31:0] lo, hi, d0, d1;
        rd(sp, base, lo, d0);
        rd(sp, base + 5'd4, hi, d1);
        v = {hi, lo};
    endtask

    task automatic clear_pin(input int p);
        if (p < 32) wr(1'b1, 5'h10, 32'd1 << p);
        else        wr(1'b1, 5'h14, 32'd1 << (p - 32));
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [31:0] a0, a1;

        waitc(3);
        rst = 1'b0;
        waitc(1);

        // R1 reset state
        chk("R1 oe", {28'd0, oe0}, 64'd0);
        chk("R1 out", {28'd0, out0}, 64'd0);
        chk("R1 irq/wake", {62'd0, irq0, wake0}, 64'd0);
        rd64(1'b1, 5'h10, v);
        chk("R1 status", v, 64'd0);

        // R2 drive registers, both words
        wr(1'b0, 5'h00, 32'hA5A5_0F0F);
        wr(1'b0, 5'h04, 32'hFFFF_FFFF);
        chk("R2 oe", {28'd0, oe0}, 64'hF_A5A5_0F0F);
        rd(1'b0, 5'h04, a0, a1);
        chk("R11 upper oe word masked", {32'd0, a0}, 64'h0000_000F);
        wr(1'b0, 5'h18, 32'h1357_9BDF);
        wr(1'b0, 5'h1C, 32'h0000_0005);
        chk("R2 out", {28'd0, out0}, 64'h5_1357_9BDF);
        wr(1'b0, 5'h04, 32'h0000_0002);
        chk("R2 upper write leaves lower", {28'd0, oe0}, 64'h2_A5A5_0F0F);

        // R11 hole offset, misaligned access, narrow instance
        rd(1'b0, 5'h08, a0, a1);
        chk("R11 hole offset", {32'd0, a0}, 64'd0);
        rd(1'b0, 5'h01, a0, a1);
        chk("R11 misaligned read", {32'd0, a0}, 64'd0);
        wr(1'b0, 5'h19, 32'hFFFF_FFFF);
        chk("R11 misaligned write", {28'd0, out0}, 64'h5_1357_9BDF);
        wr(1'b0, 5'h00, 32'hFFFF_FFFF);
        rd(1'b0, 5'h00, a0, a1);
        chk("R11 30-pin word0", {32'd0, a1}, 64'h3FFF_FFFF);
        rd(1'b0, 5'h04, a0, a1);
        chk("R11 30-pin word1", {32'd0, a1}, 64'd0);

        // R3 synchronizer depth and read-only level
        @(negedge clk);
        pins0 = 36'h9_1234_5678;
        waitc(1);
        rd64(1'b0, 5'h10, v);
        chk("R3 level after one edge", v, 64'd0);
        waitc(1);
        rd64(1'b0, 5'h10, v);
        chk("R3 level after two edges", v, 64'h9_1234_5678);
        wr(1'b0, 5'h10, 32'h0);
        rd64(1'b0, 5'h10, v);
        chk("R3 level write ignored", v, 64'h9_1234_5678);

        // R9 latches while disabled, irq stays low
        waitc(2);
        rd64(1'b1, 5'h10, v);
        chk("R9 status latched disabled", v, 64'h9_1234_5678);
        chk("R9 irq low when disabled", {63'd0, irq0}, 64'd0);

        // R10 wake independent of enable (pin 35)
        wr(1'b1, 5'h1C, 32'h8);
        chk("R10 wake raised", {63'd0, wake0}, 64'd1);
        pins0 = '0;
        waitc(4);
        wr(1'b1, 5'h10, 32'hFFFF_FFFF);
        wr(1'b1, 5'h14, 32'hFFFF_FFFF);
        rd64(1'b1, 5'h10, v);
        chk("R6 bulk clear", v, 64'd0);
        chk("R10 wake drops", {63'd0, wake0}, 64'd0);
        wr(1'b1, 5'h1C, 32'h0);

        // R4/R5 rising sweep over every pin
        wr(1'b1, 5'h00, 32'hFFFF_FFFF);
        wr(1'b1, 5'h04, 32'hFFFF_FFFF);
        rd64(1'b1, 5'h00, v);
        chk("R4 enable readback", v, 64'hF_FFFF_FFFF);
        for (int p = 0; p < 36; p++) begin
            pins0[p] = 1'b1;
            waitc(4);
            rd64(1'b1, 5'h10, v);
            chk($sformatf("R5 rise pin %0d", p), v, 64'd1 << p);
            chk($sformatf("R9 irq pin %0d", p), {63'd0, irq0}, 64'd1);
            clear_pin(p);
            rd64(1'b1, 5'h10, v);
            chk($sformatf("R6 clear pin %0d", p), v, 64'd0);
            pins0[p] = 1'b0;
            waitc(4);
            rd64(1'b1, 5'h10, v);
            chk($sformatf("R5 fall ignored pin %0d", p), v, 64'd0);
        end

        // R8 polarity flips with all pins low create nothing
        wr(1'b1, 5'h08, 32'hFFFF_FFFF);
        wr(1'b1, 5'h0C, 32'hFFFF_FFFF);
        waitc(3);
        rd64(1'b1, 5'h10, v);
        chk("R8 polarity to falling", v, 64'd0);
        rd64(1'b1, 5'h08, v);
        chk("R4 polarity readback", v, 64'hF_FFFF_FFFF);

        // R5 falling sweep near word edges
        foreach (pins0[p]) begin
            if (p == 0 || p == 17 || p == 31 || p == 32 || p == 35) begin
                pins0[p] = 1'b1;
                waitc(4);
                rd64(1'b1, 5'h10, v);
                chk($sformatf("R5 rise ignored falling pin %0d", p), v, 64'd0);
                pins0[p] = 1'b0;
                waitc(4);
                rd64(1'b1, 5'h10, v);
                chk($sformatf("R5 fall pin %0d", p), v, 64'd1 << p);
                clear_pin(p);
            end
        end

        // R8 polarity toggling with pin 5 held high
        pins0[5] = 1'b1;
        waitc(4);
        clear_pin(5);
        wr(1'b1, 5'h08, 32'h0);
        waitc(3);
        wr(1'b1, 5'h08, 32'hFFFF_FFFF);
        waitc(3);
        wr(1'b1, 5'h08, 32'h0);
        waitc(3);
        rd64(1'b1, 5'h10, v);
        chk("R8 polarity toggle held high", v, 64'd0);
        pins0[5] = 1'b0;
        waitc(4);

        // R7 edge coincident with clear on pin 7 (rising)
        pins0[7] = 1'b1;
        waitc(4);
        pins0[7] = 1'b0;
        waitc(4);
        wr(1'b1, 5'h10, 32'h0);
        rd64(1'b1, 5'h10, v);
        chk("R6 zero write keeps", v, 64'h80);
        @(negedge clk);
        pins0[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        space = 1'b1; addr = 5'h10; wdata = 32'h80; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd64(1'b1, 5'h10, v);
        chk("R7 event beats clear", v, 64'h80);
        clear_pin(7);
        rd64(1'b1, 5'h10, v);
        chk("R6 later clear", v, 64'd0);
        chk("R9 irq off after clear", {63'd0, irq0}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule